// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block joins two equal-width buses, A and B, and can move data in either direction. Each direction owns a storage register with its own capture clock. The A-to-B register takes a snapshot of bus A, and the B-to-A register takes a snapshot of bus B. An active-low enable and a direction input decide which bus, if either, the block drives. A per-direction source select decides whether the driven bus carries the live value from the opposite bus or the contents of that direction's register.

Each tri-state pin group is split into an input vector, an output vector and one output-enable bit, so the block stays synthesizable. The output-enable decode and the source muxes are purely combinational. Only the two registers hold state, and neither register has a reset. Both registers keep capturing while the block drives neither bus. A system can therefore store a value from one bus while isolated and replay it later.

Top module: `regbus_xcvr`

## Requirements
- R1: On every rising edge of `clk_ab`, the A-to-B register loads the value on `a_in`, whatever the state of the enable, direction and select inputs.
- R2: On every rising edge of `clk_ba`, the B-to-A register loads the value on `b_in`, whatever the state of the enable, direction and select inputs.
- R3: While `en_n` is 1, `a_oe` and `b_oe` are both 0, and both registers still capture on their clock edges.
- R4: While `en_n` is 0, `dir` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir` = 0 gives `a_oe` = 1 and `b_oe` = 0. This decode is combinational.
- R5: `a_oe` and `b_oe` are never 1 at the same time.
- R6: With `sel_ab` = 0, `b_out` equals `a_in` combinationally.
- R7: With `sel_ba` = 0, `a_out` equals `b_in` combinationally.
- R8: With `sel_ab` = 1, `b_out` equals the A-to-B register. It shows a new capture directly after the `clk_ab` edge and ignores changes on `a_in` between edges.
- R9: With `sel_ba` = 1, `a_out` equals the B-to-A register. It shows a new capture directly after the `clk_ba` edge and ignores changes on `b_in` between edges.
- R10: In pass-through mode, a capture edge stores the live value while `b_out` (or `a_out`) keeps following the live input.
- R11: A `clk_ab` edge leaves the B-to-A register unchanged, and a `clk_ba` edge leaves the A-to-B register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register (rising edge) |
| clk_ba | input | 1 | Capture clock of the B-to-A register (rising edge) |
| en_n | input | 1 | Active-low output enable |
| dir | input | 1 | Direction: 1 drives B, 0 drives A |
| sel_ab | input | 1 | Source for B: 0 = live A, 1 = stored A-to-B register |
| sel_ba | input | 1 | Source for A: 0 = live B, 1 = stored B-to-A register |
| a_in | input | WIDTH | Value seen on bus A |
| a_out | output | WIDTH | Value offered to bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | WIDTH | Value seen on bus B |
| b_out | output | WIDTH | Value offered to bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The enables and the live paths are combinational, so their results are due in the same cycle as the input change. The bench samples them 2 ns after it drives the inputs, before any capture edge. A stored value is due directly after its capture edge, so the bench reads it 2 ns after the edge falls and again after it has changed the live input. The expected register contents are tracked in the bench from the values it presented at each edge. Both registers are loaded while the block is isolated before any stored path is checked, which also exercises capture with both outputs off.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_t;

  localparam int NUM_DIR = 2;
  localparam int DIR_AB  = 0;
  localparam int DIR_BA  = 1;
endpackage

// File: rtl/regbus_capture.sv
module regbus_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // No reset: contents are defined by the first capture edge.
  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/regbus_drive_decode.sv
module regbus_drive_decode
  import regbus_pkg::*;
(
  input  logic en_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);
  drive_t drive;

  always_comb begin
    if (en_n)     drive = DRV_NONE;
    else if (dir) drive = DRV_B;
    else          drive = DRV_A;
  end

  assign a_oe = (drive == DRV_A);
  assign b_oe = (drive == DRV_B);

  always_comb begin
    AST_ONE_DRIVER: assert (!(a_oe && b_oe)) else $error("both buses driven"); // R5
  end
endmodule

// File: rtl/regbus_src_mux.sv
module regbus_src_mux #(
  parameter int WIDTH = 8
) (
  input  logic             use_stored,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] out
);
  assign out = use_stored ? stored : live;
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             en_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  // Per-direction views: index DIR_AB carries A->B, DIR_BA carries B->A.
  logic [NUM_DIR-1:0] cap_clk;
  logic [NUM_DIR-1:0] use_reg;
  logic [WIDTH-1:0]   src_live [NUM_DIR];
  logic [WIDTH-1:0]   held     [NUM_DIR];
  logic [WIDTH-1:0]   dst_out  [NUM_DIR];

  assign cap_clk[DIR_AB]  = clk_ab;
  assign cap_clk[DIR_BA]  = clk_ba;
  assign use_reg[DIR_AB]  = sel_ab;
  assign use_reg[DIR_BA]  = sel_ba;
  assign src_live[DIR_AB] = a_in;
  assign src_live[DIR_BA] = b_in;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_path
    regbus_capture #(.WIDTH(WIDTH)) u_reg (
      .clk (cap_clk[g]),
      .d   (src_live[g]),
      .q   (held[g])
    );

    regbus_src_mux #(.WIDTH(WIDTH)) u_mux (
      .use_stored (use_reg[g]),
      .live       (src_live[g]),
      .stored     (held[g]),
      .out        (dst_out[g])
    );
  end

  assign b_out = dst_out[DIR_AB];
  assign a_out = dst_out[DIR_BA];

  regbus_drive_decode u_dec (
    .en_n (en_n),
    .dir  (dir),
    .a_oe (a_oe),
    .b_oe (b_oe)
  );

  always_comb begin
    if (en_n === 1'b1)
      AST_ISOLATED: assert (!a_oe && !b_oe) else $error("driving while disabled"); // R3
    if (en_n === 1'b0 && dir === 1'b1)
      AST_DRIVE_B: assert (b_oe && !a_oe) else $error("B not selected"); // R4
    if (en_n === 1'b0 && dir === 1'b0)
      AST_DRIVE_A: assert (a_oe && !b_oe) else $error("A not selected"); // R4
    if (sel_ab === 1'b0 && !$isunknown(a_in))
      AST_LIVE_AB: assert (b_out == a_in) else $error("live A->B broken"); // R6
    if (sel_ba === 1'b0 && !$isunknown(b_in))
      AST_LIVE_BA: assert (a_out == b_in) else $error("live B->A broken"); // R7
  end
endmodule

// File: tb/sim_regbus_xcvr.sv
`timescale 1ns/1ps
module sim_regbus_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic clk_ab = 1'b0, clk_ba = 1'b0;
  logic en_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [W-1:0] exp_ab, exp_ba;

  regbus_xcvr #(.WIDTH(W)) u0 (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .en_n(en_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out),
    .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_ab();
    @(posedge clk); #2 clk_ab = 1'b1; exp_ab = a_in; #2 clk_ab = 1'b0; #2;
  endtask

  task automatic pulse_ba();
    @(posedge clk); #2 clk_ba = 1'b1; exp_ba = b_in; #2 clk_ba = 1'b0; #2;
  endtask

  initial begin
    #3;
    // reset-time state: disabled, no bus driven (R3)
    check(a_oe == 1'b0 && b_oe == 1'b0, "R3 idle", {6'd0, a_oe, b_oe}, '0);

    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] la, lb;
      // load both registers while isolated (R1, R2, R3)
      en_n = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
      a_in = W'((k * 37 + 11) & 255);
      b_in = ~a_in;
      pulse_ab();
      pulse_ba();
      la = W'(a_in + 8'h3C);
      lb = W'(b_in + 8'hC3);
      a_in = la; b_in = lb;
      for (int c = 0; c < 16; c++) begin
        logic e_aoe, e_boe;
        en_n = c[3]; dir = c[2]; sel_ab = c[1]; sel_ba = c[0];
        #2;
        e_aoe = !en_n && !dir;
        e_boe = !en_n && dir;
        check(a_oe == e_aoe && b_oe == e_boe, en_n ? "R3 oe" : "R4 oe",
              {6'd0, a_oe, b_oe}, {6'd0, e_aoe, e_boe});
        check(!(a_oe && b_oe), "R5", {6'd0, a_oe, b_oe}, '0);
        check(b_out == (sel_ab ? exp_ab : la), sel_ab ? "R1/R8 b_out" : "R6 b_out", b_out, sel_ab ? exp_ab : la);
        check(a_out == (sel_ba ? exp_ba : lb), sel_ba ? "R2/R9 a_out" : "R7 a_out", a_out, sel_ba ? exp_ba : lb);
      end
    end

    // R8: stored value ignores live changes, updates right after edge
    en_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
    a_in = 8'hA5; pulse_ab();
    a_in = 8'h11; #2;
    check(b_out == 8'hA5, "R8 hold", b_out, 8'hA5);
    pulse_ab();
    check(b_out == 8'h11, "R8 update", b_out, 8'h11);

    // R9 on the A side
    dir = 1'b0;
    b_in = 8'h7E; pulse_ba();
    b_in = 8'h81; #2;
    check(a_out == 8'h7E, "R9 hold", a_out, 8'h7E);
    pulse_ba();
    check(a_out == 8'h81, "R9 update", a_out, 8'h81);

    // R11: clocks are independent
    a_in = 8'h3F; pulse_ab();
    check(a_out == 8'h81, "R11 ba kept", a_out, 8'h81);
    dir = 1'b1; b_in = 8'hC0; pulse_ba();
    check(b_out == 8'h3F, "R11 ab kept", b_out, 8'h3F);

    // R10: capture during pass-through
    sel_ab = 1'b0; a_in = 8'h96; #2;
    check(b_out == 8'h96, "R10 live before", b_out, 8'h96);
    pulse_ab();
    check(b_out == 8'h96, "R10 live after", b_out, 8'h96);
    a_in = 8'h00; #2;
    check(b_out == 8'h00, "R10 live follows", b_out, 8'h00);
    sel_ab = 1'b1; #2;
    check(b_out == 8'h96, "R10 stored", b_out, 8'h96);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule